// File: doc/BRIEF.md
# Firmware Image Header Validator

This block checks a firmware image that sits in a byte-wide buffer before anything boots from it. After a `start` pulse it reads the image through a one-byte read port. It checks the trailing checksum and works out where the section header lives. From the header it takes the placement and length of the instruction section and the data section. It then checks the alignment and bounds of both sections and confirms that a version string is present. It finishes with a one-cycle `done` pulse, an error code, and the resolved section offsets and lengths. A loader uses these outputs to decide whether to copy the sections into the target memories and where to copy them from.

The controller is a single state machine with these states:

- S_IDLE waits for `start`. It goes to S_DONE when the image is shorter than two bytes, and to S_CRC otherwise.
- S_CRC streams the whole image through the checksum unit and captures the two tail bytes. On the last byte it goes to S_DONE on a mismatch or when the image is shorter than ten bytes, and to S_POFF otherwise.
- S_POFF reads the two primary-offset bytes. It goes to S_HDR when the header fits inside the image, and to S_DONE otherwise.
- S_HDR reads the twelve field bytes of the header, then goes to S_SECT.
- S_SECT runs the alignment and bounds checks in a single cycle. It goes to S_VER when all of them pass, and to S_DONE otherwise.
- S_VER reads the first version byte, then goes to S_DONE.
- S_DONE raises `done` for one cycle, then returns to S_IDLE.

`image_size` must be held stable from `start` until `done`.

Top module: `fw_image_checker`

## Requirements
- R1: A `start` pulse in idle begins a check. `busy` stays high until `done`, and `done` is high for exactly one cycle. A `start` pulse while busy is ignored and does not queue a second run.
- R2: Each read fetches one byte. `rd_data` is valid the cycle after `rd_en`. Every address read is below `image_size`.
- R3: The checksum is CRC-16 with polynomial 0x1021, initial value 0, processed MSB first with no reflection. It covers bytes 0 to size-3. It is compared with the last two bytes, where byte size-2 is the high byte. A mismatch, or an image shorter than 2 bytes, gives error code 1.
- R4: The primary offset P is the little-endian 16-bit value at bytes 8 (low) and 9 (high), shifted left by 12. An image shorter than 10 bytes gives error code 2.
- R5: The header starts at P+0x300: 4 pad bytes, then four 3-byte little-endian fields in this order: instruction offset, instruction length, data offset, data length. If P+0x310 exceeds the image size, the error code is 2.
- R6: A section length that is not a multiple of 4 gives error code 3.
- R7: A section whose P+offset+length exceeds the image size gives error code 4. A section that ends exactly at the image size passes.
- R8: The version string starts at P+data offset+0x200. If P+data offset+0x240 exceeds the image size, or if its first byte is zero, the error code is 5.
- R9: Checks run in this order, and the first failure ends the run: checksum, header, instruction alignment, instruction bounds, data alignment, data bounds, version. Code 0 means the image passed.
- R10: On a pass, `isec_off` = P+instruction offset, `isec_len` = instruction length, `dsec_off` = P+data offset and `dsec_len` = data length. These outputs and `err_code` hold until the next accepted `start`.
- R11: After reset, `busy`, `done` and `rd_en` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (taken in idle only) |
| image_size | input | AW | Image length in bytes |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | AW | Byte address of the read |
| rd_data | input | 8 | Read byte, one cycle after `rd_en` |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 pass, 1 checksum, 2 header, 3 alignment, 4 section bounds, 5 version |
| isec_off | output | AW | Resolved instruction section offset |
| isec_len | output | AW | Instruction section length |
| dsec_off | output | AW | Resolved data section offset |
| dsec_len | output | AW | Data section length |

## Verification
The assertions watch, on every cycle, the handshake and the read port:

- `done` lasts one cycle and only ever comes inside a busy period.
- A busy period does not end before `done`.
- No read leaves the image or happens while idle.
- `err_code` holds while idle.

The bench's scenarios alone can show that the checksum value is right, that the header fields are decoded in the right byte order, that the offsets are resolved correctly, and that the first failing check wins when several are broken at once. The bench shows these by building images with known contents and comparing the reported code and offsets against values worked out from the format rules.

// File: rtl/fwchk_pkg.sv
package fwchk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CRC,
        S_POFF,
        S_HDR,
        S_SECT,
        S_VER,
        S_DONE
    } fsm_t;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_CRC   = 3'd1;
    localparam logic [2:0] ERR_HDR   = 3'd2;
    localparam logic [2:0] ERR_ALIGN = 3'd3;
    localparam logic [2:0] ERR_SECT  = 3'd4;
    localparam logic [2:0] ERR_VER   = 3'd5;

    localparam int POFF_AT    = 8;
    localparam int POFF_SHIFT = 12;
    localparam int HDR_REL    = 'h300;
    localparam int HDR_PAD    = 4;
    localparam int HDR_LEN    = 16;
    localparam int FIELD_LEN  = 12;
    localparam int VER_REL    = 'h200;
    localparam int VER_LEN    = 64;

    localparam logic [15:0] CRC_POLY = 16'h1021;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fwchk_fetch.sv
module fwchk_fetch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] count,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          byte_vld,
    output logic [7:0]    byte_data,
    output logic [AW-1:0] byte_idx,
    output logic          byte_last
);
    logic          active;
    logic [AW-1:0] addr;
    logic [AW-1:0] remain;
    logic [AW-1:0] nidx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            addr      <= '0;
            remain    <= '0;
            nidx      <= '0;
            byte_vld  <= 1'b0;
            byte_last <= 1'b0;
            byte_idx  <= '0;
        end else begin
            byte_vld  <= active;
            byte_last <= active && (remain == AW'(1));
            if (active) begin
                byte_idx <= nidx;
                nidx     <= nidx + AW'(1);
                addr     <= addr + AW'(1);
                remain   <= remain - AW'(1);
                if (remain == AW'(1)) begin
                    active <= 1'b0;
                end
            end else if (go) begin
                active <= 1'b1;
                addr   <= base;
                remain <= count;
                nidx   <= '0;
            end
        end
    end

    assign rd_en     = active;
    assign rd_addr   = addr;
    assign byte_data = rd_data;

endmodule

// File: rtl/fwchk_crc.sv
module fwchk_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import fwchk_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc16_step(crc, din);
        end
    end

endmodule

// File: rtl/fw_image_checker.sv
module fw_image_checker #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] image_size,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          busy,
    output logic          done,
    output logic [2:0]    err_code,
    output logic [AW-1:0] isec_off,
    output logic [AW-1:0] isec_len,
    output logic [AW-1:0] dsec_off,
    output logic [AW-1:0] dsec_len
);
    import fwchk_pkg::*;

    localparam int WW = AW + 2;

    fsm_t state, state_nx;
    logic [2:0]    err_nx;
    logic          launched;
    logic          fetch_go;
    logic [AW-1:0] fetch_base;
    logic [AW-1:0] fetch_cnt;
    logic          byte_vld;
    logic [7:0]    byte_data;
    logic [AW-1:0] byte_idx;
    logic          byte_last;
    logic [15:0]   crc_val;
    logic          crc_clr;
    logic          crc_en;
    logic [7:0]    tail_hi;
    logic [7:0]    poff_lo;
    logic [AW-1:0] prim;
    logic [AW-1:0] prim_new;
    logic [95:0]   hdr;
    logic [23:0]   f_ioff, f_isz, f_doff, f_dsz;
    logic [WW-1:0] size_w, hdr_end_w, i_end_w, d_end_w, v_end_w;
    logic          body_byte;

    fwchk_fetch #(.AW(AW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (fetch_go),
        .base      (fetch_base),
        .count     (fetch_cnt),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_idx  (byte_idx),
        .byte_last (byte_last)
    );

    fwchk_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (byte_data),
        .crc   (crc_val)
    );

    assign f_ioff    = hdr[23:0];
    assign f_isz     = hdr[47:24];
    assign f_doff    = hdr[71:48];
    assign f_dsz     = hdr[95:72];
    assign size_w    = WW'(image_size);
    assign prim_new  = AW'({byte_data, poff_lo}) << POFF_SHIFT;
    assign hdr_end_w = WW'(prim_new) + WW'(HDR_REL + HDR_LEN);
    assign i_end_w   = WW'(prim) + WW'(f_ioff) + WW'(f_isz);
    assign d_end_w   = WW'(prim) + WW'(f_doff) + WW'(f_dsz);
    assign v_end_w   = WW'(prim) + WW'(f_doff) + WW'(VER_REL + VER_LEN);
    assign body_byte = byte_vld && (byte_idx < image_size - AW'(2));

    assign crc_clr = (state == S_IDLE) && start;
    assign crc_en  = (state == S_CRC) && body_byte;
    assign busy    = (state != S_IDLE);
    assign done    = (state == S_DONE);

    // Read request selection per state
    always_comb begin
        fetch_base = '0;
        fetch_cnt  = AW'(1);
        fetch_go   = 1'b0;
        unique case (state)
            S_CRC: begin
                fetch_cnt = image_size;
                fetch_go  = !launched;
            end
            S_POFF: begin
                fetch_base = AW'(POFF_AT);
                fetch_cnt  = AW'(2);
                fetch_go   = !launched;
            end
            S_HDR: begin
                fetch_base = prim + AW'(HDR_REL + HDR_PAD);
                fetch_cnt  = AW'(FIELD_LEN);
                fetch_go   = !launched;
            end
            S_VER: begin
                fetch_base = dsec_off + AW'(VER_REL);
                fetch_go   = !launched;
            end
            default: ;
        endcase
    end

    // Next state and failure code
    always_comb begin
        state_nx = state;
        err_nx   = ERR_NONE;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (image_size < AW'(2)) begin
                        state_nx = S_DONE;
                        err_nx   = ERR_CRC;
                    end else begin
                        state_nx = S_CRC;
                    end
                end
            end
            S_CRC: begin
                if (byte_vld && byte_last) begin
                    if ({tail_hi, byte_data} != crc_val) begin
                        state_nx = S_DONE;
                        err_nx   = ERR_CRC;
                    end else if (image_size < AW'(POFF_AT + 2)) begin
                        state_nx = S_DONE;
                        err_nx   = ERR_HDR;
                    end else begin
                        state_nx = S_POFF;
                    end
                end
            end
            S_POFF: begin
                if (byte_vld && byte_last) begin
                    if (hdr_end_w > size_w) begin
                        state_nx = S_DONE;
                        err_nx   = ERR_HDR;
                    end else begin
                        state_nx = S_HDR;
                    end
                end
            end
            S_HDR: begin
                if (byte_vld && byte_last) begin
                    state_nx = S_SECT;
                end
            end
            S_SECT: begin
                state_nx = S_DONE;
                if (f_isz[1:0] != 2'b00) begin
                    err_nx = ERR_ALIGN;
                end else if (i_end_w > size_w) begin
                    err_nx = ERR_SECT;
                end else if (f_dsz[1:0] != 2'b00) begin
                    err_nx = ERR_ALIGN;
                end else if (d_end_w > size_w) begin
                    err_nx = ERR_SECT;
                end else if (v_end_w > size_w) begin
                    err_nx = ERR_VER;
                end else begin
                    state_nx = S_VER;
                end
            end
            S_VER: begin
                if (byte_vld && byte_last) begin
                    state_nx = S_DONE;
                    err_nx   = (byte_data == 8'h00) ? ERR_VER : ERR_NONE;
                end
            end
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launched <= 1'b0;
            err_code <= ERR_NONE;
            isec_off <= '0;
            isec_len <= '0;
            dsec_off <= '0;
            dsec_len <= '0;
            tail_hi  <= '0;
            poff_lo  <= '0;
            prim     <= '0;
            hdr      <= '0;
        end else begin
            launched <= (state_nx == state) ? (launched | fetch_go) : 1'b0;
            if (state == S_IDLE && start) begin
                err_code <= ERR_NONE;
                isec_off <= '0;
                isec_len <= '0;
                dsec_off <= '0;
                dsec_len <= '0;
            end
            if (state_nx == S_DONE && state != S_DONE) begin
                err_code <= err_nx;
            end
            if (state == S_CRC && byte_vld && byte_idx == image_size - AW'(2)) begin
                tail_hi <= byte_data;
            end
            if (state == S_POFF && byte_vld) begin
                if (byte_last) begin
                    prim <= prim_new;
                end else begin
                    poff_lo <= byte_data;
                end
            end
            if (state == S_HDR && byte_vld) begin
                hdr <= {byte_data, hdr[95:8]};
            end
            if (state == S_SECT) begin
                isec_off <= prim + AW'(f_ioff);
                isec_len <= AW'(f_isz);
                dsec_off <= prim + AW'(f_doff);
                dsec_len <= AW'(f_dsz);
            end
        end
    end

endmodule

// File: rtl/fwchk_props.sv
module fwchk_props #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] image_size,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          busy,
    input logic          done,
    input logic [2:0]    err_code
);
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_busy_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_read_in_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < image_size));

    assert_read_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code <= 3'd5));

    assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err_code));

endmodule

bind fw_image_checker fwchk_props #(.AW(AW)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .image_size (image_size),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .done       (done),
    .err_code   (err_code)
);

// File: tb/fw_image_checker_tb.sv
module fw_image_checker_tb;
    localparam int AW    = 32;
    localparam int MEMSZ = 6144;

    typedef struct packed {
        logic [15:0] poff;
        logic [23:0] ioff;
        logic [23:0] isz;
        logic [23:0] doff;
        logic [23:0] dsz;
        logic [31:0] size;
        logic [7:0]  ver;
        logic        bad;
        logic [2:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'd0, 24'h400, 24'h040, 24'h500, 24'h300, 32'h800,  8'h41, 1'b0, 3'd0}, // R7 exact end
        '{16'd0, 24'h400, 24'h040, 24'h500, 24'h300, 32'h800,  8'h41, 1'b1, 3'd1}, // R3
        '{16'd0, 24'h400, 24'h042, 24'h500, 24'h300, 32'h800,  8'h41, 1'b0, 3'd3}, // R6
        '{16'd0, 24'h7F0, 24'h020, 24'h500, 24'h300, 32'h800,  8'h41, 1'b0, 3'd4}, // R7
        '{16'd0, 24'h400, 24'h040, 24'h500, 24'h302, 32'h800,  8'h41, 1'b0, 3'd3}, // R6
        '{16'd0, 24'h400, 24'h040, 24'h500, 24'h300, 32'h800,  8'h00, 1'b0, 3'd5}, // R8
        '{16'd0, 24'h400, 24'h040, 24'h5D0, 24'h010, 32'h800,  8'h41, 1'b0, 3'd5}, // R8
        '{16'd0, 24'h400, 24'h040, 24'h500, 24'h300, 32'h30F,  8'h41, 1'b0, 3'd2}, // R5
        '{16'd1, 24'h400, 24'h080, 24'h500, 24'h040, 32'h1780, 8'h5A, 1'b0, 3'd0}, // R4
        '{16'd1, 24'h400, 24'h080, 24'h500, 24'h040, 32'h1000, 8'h5A, 1'b0, 3'd2}, // R5
        '{16'd0, 24'h400, 24'h042, 24'h500, 24'h300, 32'h800,  8'h41, 1'b1, 3'd1}, // R9
        '{16'd0, 24'h7F0, 24'h042, 24'h500, 24'h300, 32'h800,  8'h41, 1'b0, 3'd3}, // R9
        '{16'd0, 24'h7F0, 24'h020, 24'h500, 24'h302, 32'h800,  8'h41, 1'b0, 3'd4}  // R9
    };

    logic          clk;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] image_size;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          busy;
    logic          done;
    logic [2:0]    err_code;
    logic [AW-1:0] isec_off, isec_len, dsec_off, dsec_len;

    logic [7:0] mem [MEMSZ];
    int checks;
    int fails;
    int cycles;

    fw_image_checker #(.AW(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .image_size (image_size),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done),
        .err_code   (err_code),
        .isec_off   (isec_off),
        .isec_len   (isec_len),
        .dsec_off   (dsec_off),
        .dsec_len   (dsec_len)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr % MEMSZ];
    end

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            if (r[15] ^ b[k]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic build(input vec_t v);
        int h;
        int va;
        logic [15:0] c;
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(i * 7 + 3);
        mem[8] = v.poff[7:0];
        mem[9] = v.poff[15:8];
        h = int'(v.poff) * 4096 + 'h300;
        if (h + 16 <= MEMSZ) begin
            for (int j = 0; j < 3; j++) begin
                mem[h + 4 + j]  = v.ioff[8*j +: 8];
                mem[h + 7 + j]  = v.isz[8*j +: 8];
                mem[h + 10 + j] = v.doff[8*j +: 8];
                mem[h + 13 + j] = v.dsz[8*j +: 8];
            end
        end
        va = int'(v.poff) * 4096 + int'(v.doff) + 'h200;
        if (va < MEMSZ) mem[va] = v.ver;
        if (v.size >= 2) begin
            c = 16'h0000;
            for (int i = 0; i < int'(v.size) - 2; i++) c = ref_crc(c, mem[i]);
            if (v.bad) c = c ^ 16'h0001;
            mem[v.size - 2] = c[15:8];
            mem[v.size - 1] = c[7:0];
        end
    endtask

    task automatic run(input logic [31:0] size, output bit finished);
        int w;
        @(negedge clk);
        image_size = size;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finished = 1'b0;
        w = 0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        finished = done;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        bit fin;
        logic [31:0] p;
        build(v);
        run(v.size, fin);
        check({req, " done seen"}, 32'(fin), 32'd1);
        check({req, " error code"}, 32'(err_code), 32'(v.exp));
        if (v.exp == 3'd0) begin
            p = 32'(v.poff) << 12;
            check("R10 isec_off", isec_off, p + 32'(v.ioff));
            check("R10 isec_len", isec_len, 32'(v.isz));
            check("R10 dsec_off", dsec_off, p + 32'(v.doff));
            check("R10 dsec_len", dsec_len, 32'(v.dsz));
        end
    endtask

    initial begin
        bit fin;
        vec_t t;
        checks = 0;
        fails = 0;
        start = 1'b0;
        image_size = '0;
        rst_n = 1'b0;
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", 32'(busy), 32'd0);
        check("R11 done", 32'(done), 32'd0);
        check("R11 rd_en", 32'(rd_en), 32'd0);
        check("R11 err_code", 32'(err_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            run_vec(VECS[n], $sformatf("R9 vector %0d", n));
        end

        // R3 image of one byte
        t = VECS[0]; t.size = 32'd1; t.exp = 3'd1;
        run_vec(t, "R3 size 1");
        // R3 R4 two-byte image, empty checksum passes, then too short for offset
        t = VECS[0]; t.size = 32'd2; t.exp = 3'd2;
        run_vec(t, "R4 size 2");
        t = VECS[0]; t.size = 32'd2; t.bad = 1'b1; t.exp = 3'd1;
        run_vec(t, "R3 size 2 bad");
        t = VECS[0]; t.size = 32'd9; t.exp = 3'd2;
        run_vec(t, "R4 size 9");

        // R10 outputs hold after a pass
        run_vec(VECS[8], "R10 pass");
        repeat (10) @(negedge clk);
        check("R10 hold err", 32'(err_code), 32'd0);
        check("R10 hold isec_off", isec_off, 32'h1400);
        check("R10 hold dsec_off", dsec_off, 32'h1500);

        // R1 start while busy is ignored
        build(VECS[0]);
        @(negedge clk);
        image_size = VECS[0].size;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check("R1 busy mid-run", 32'(busy), 32'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fin = 1'b0;
        for (int w = 0; w < 20000 && !fin; w++) begin
            @(negedge clk);
            fin = done;
        end
        check("R1 done seen", 32'(fin), 32'd1);
        check("R1 result", 32'(err_code), 32'd0);
        @(negedge clk);
        check("R1 done one cycle", 32'(done), 32'd0);
        repeat (5) @(negedge clk);
        check("R1 no queued run", 32'(busy), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule